// File: doc/BRIEF.md
# Systolic Edit Distance Array

This block measures how far a streamed target sequence is from a stored query sequence. The measure is the smallest number of single-symbol edits that turns one into the other, where an edit inserts, removes or replaces one symbol. A chain of `NCELL` identical cells does the work. Each cell keeps one query symbol and owns one row of the dynamic-programming matrix. Target symbols, with the partial distances of the row above, march down the chain one cell per clock. The cells therefore fill the matrix as a diagonal wavefront, and the total work grows with the product of the two lengths.

The host writes the query symbols through a plain write port and then streams targets through a valid/ready input. Each target token carries a `last` flag that closes its sequence. Two rules govern back-pressure. `in_ready` is low in any cycle in which a query write is present, and it is high otherwise. A token moves only on a rising edge where `in_valid` and `in_ready` are both high, and the host must hold the token stable until that edge. The result side has no back-pressure. `res_valid` pulses for one cycle with `res_dist` for each finished sequence. Sequences may follow each other with no gap. Queries should be rewritten only while no target is in flight.

Top module: `sed_array`

## Requirements
- R1: After reset `res_valid` is 0, and `in_ready` is 1 while `q_wr` is 0.
- R2: A cycle with `q_wr`=1 stores `q_sym` as query position `q_idx`, where index 0 is the query's first symbol and sits next to the input. In such a cycle `in_ready` is 0 and no target token is taken.
- R3: A token is taken only on an edge where `in_valid` and `in_ready` are both 1. Idle cycles between tokens, whether inside a sequence or between sequences, do not change any result.
- R4: For a target of length M, the reported distance equals D(NCELL,M). Here D(i,0)=i, D(0,j)=j, and D(i,j) is the minimum of D(i-1,j)+1, D(i,j-1)+1 and D(i-1,j-1)+c, with c=0 when query symbol i equals target symbol j and c=1 otherwise.
- R5: If the last token of a sequence is taken on rising edge k, then `res_valid` is 1 only between edges k+NCELL-1 and k+NCELL, so it is registered on the NCELL-th edge counting edge k as the first.
- R6: The token after a `last` token opens a new sequence, even when it arrives on the very next edge. A sequence of one token is legal.
- R7: Distances saturate at 2^DW-1 instead of wrapping, so the result is min(true distance, 2^DW-1).
- R8: Exactly one result appears per sequence, and results come out in the order the sequences went in.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| q_wr | input | 1 | Query symbol write strobe |
| q_idx | input | max(1,clog2(NCELL)) | Query position to write (0 = first) |
| q_sym | input | SW | Query symbol value |
| in_valid | input | 1 | Target token present |
| in_ready | output | 1 | Target token can be taken this cycle |
| in_sym | input | SW | Target symbol |
| in_last | input | 1 | Token closes its sequence |
| res_valid | output | 1 | One-cycle result strobe |
| res_dist | output | DW | Edit distance of the finished sequence |

## Verification
The case that matters most is the end of one sequence and the start of the next falling in the same cycle in different cells. Then one cell folds in its row boundary for a new sequence while the cell below still finishes the old one. Every target of length one to four is streamed back-to-back against several queries to provoke this case. Each result is judged against an arithmetic table of distances. A second collision is a query write during a pending token. Holding `in_valid` high under `q_wr` provokes it, and the check is that `in_ready` stays low and no extra result appears.

// File: rtl/sed_pkg.sv
package sed_pkg;

  // Clamp an elaboration-time value to a limit (used for row boundary constants).
  function automatic int unsigned sed_clamp(int unsigned v, int unsigned lim);
    return (v > lim) ? lim : v;
  endfunction

  // Largest value a DW-bit unsigned field can hold.
  function automatic int unsigned sed_max_of(int unsigned w);
    return (w >= 32) ? 32'hFFFF_FFFF : ((32'd1 << w) - 32'd1);
  endfunction

endpackage

// File: rtl/sed_head.sv
module sed_head
  import sed_pkg::*;
#(
  parameter int SW = 2,
  parameter int DW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          q_busy,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [SW-1:0] in_sym,
  input  logic          in_last,
  output logic          h_v,
  output logic          h_first,
  output logic          h_last,
  output logic [SW-1:0] h_sym,
  output logic [DW-1:0] h_d
);
  localparam logic [DW-1:0] D_MAX = '1;
  localparam logic [DW-1:0] D_ONE = DW'(1);

  logic          mid_seq;
  logic [DW-1:0] col;
  logic          acc;

  assign in_ready = ~q_busy;
  assign acc      = in_valid & in_ready;

  // Row-zero value D(0,j)=j travels with each target symbol.
  always_comb begin
    h_v     = acc;
    h_first = ~mid_seq;
    h_last  = in_last;
    h_sym   = in_sym;
    if (!mid_seq)        h_d = D_ONE;
    else if (col == D_MAX) h_d = D_MAX;
    else                 h_d = col + D_ONE;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mid_seq <= 1'b0;
      col     <= '0;
    end else if (acc) begin
      mid_seq <= ~in_last;
      col     <= h_d;
    end
  end

endmodule

// File: rtl/sed_cell.sv
module sed_cell
  import sed_pkg::*;
#(
  parameter int SW  = 2,
  parameter int DW  = 6,
  parameter int ROW = 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          q_we,
  input  logic [SW-1:0] q_sym,
  input  logic          up_v,
  input  logic          up_first,
  input  logic          up_last,
  input  logic [SW-1:0] up_sym,
  input  logic [DW-1:0] up_d,
  output logic          dn_v,
  output logic          dn_first,
  output logic          dn_last,
  output logic [SW-1:0] dn_sym,
  output logic [DW-1:0] dn_d
);
  localparam int unsigned MAXV  = sed_max_of(DW);
  localparam logic [DW-1:0] D_MAX  = '1;
  localparam logic [DW-1:0] ROW_D  = DW'(sed_clamp(ROW, MAXV));
  localparam logic [DW-1:0] ROW_UP = DW'(sed_clamp(ROW - 1, MAXV));

  logic [SW-1:0] qsym;
  logic [DW-1:0] left_d;   // D(i, j-1)
  logic [DW-1:0] diag_d;   // D(i-1, j-1)

  logic [DW-1:0] dg, lf, c_diag, c_up, c_left, nxt;
  logic          cost;

  function automatic logic [DW-1:0] sat_inc(input logic [DW-1:0] a, input logic b);
    return (a == D_MAX) ? a : a + DW'(b);
  endfunction

  always_comb begin
    dg     = up_first ? ROW_UP : diag_d;
    lf     = up_first ? ROW_D  : left_d;
    cost   = (up_sym != qsym);
    c_diag = sat_inc(dg, cost);
    c_up   = sat_inc(up_d, 1'b1);
    c_left = sat_inc(lf, 1'b1);
    nxt    = c_diag;
    if (c_up < nxt)   nxt = c_up;
    if (c_left < nxt) nxt = c_left;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      qsym     <= '0;
      left_d   <= '0;
      diag_d   <= '0;
      dn_v     <= 1'b0;
      dn_first <= 1'b0;
      dn_last  <= 1'b0;
      dn_sym   <= '0;
      dn_d     <= '0;
    end else begin
      if (q_we) qsym <= q_sym;
      dn_v <= up_v;
      if (up_v) begin
        dn_first <= up_first;
        dn_last  <= up_last;
        dn_sym   <= up_sym;
        dn_d     <= nxt;
        left_d   <= nxt;
        diag_d   <= up_d;
      end
    end
  end

  // R4
  row_step_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dn_v |-> ({1'b0, dn_d} <= {1'b0, $past(up_d)} + 1'b1));

  // R4
  row_step_lo_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dn_v |-> ({1'b0, $past(up_d)} <= {1'b0, dn_d} + 1'b1));

  // R6
  first_col_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dn_v && dn_first) |-> (dn_d <= ROW_D));

  // R7
  sat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (up_v && up_d == D_MAX) |=> ({1'b0, dn_d} + 1'b1 >= {1'b0, D_MAX}));

endmodule

// File: rtl/sed_array.sv
module sed_array
  import sed_pkg::*;
#(
  parameter  int NCELL = 8,
  parameter  int SW    = 2,
  parameter  int DW    = 6,
  localparam int IW    = (NCELL > 1) ? $clog2(NCELL) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          q_wr,
  input  logic [IW-1:0] q_idx,
  input  logic [SW-1:0] q_sym,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [SW-1:0] in_sym,
  input  logic          in_last,
  output logic          res_valid,
  output logic [DW-1:0] res_dist
);
  logic          lk_v     [0:NCELL];
  logic          lk_first [0:NCELL];
  logic          lk_last  [0:NCELL];
  logic [SW-1:0] lk_sym   [0:NCELL];
  logic [DW-1:0] lk_d     [0:NCELL];

  sed_head #(.SW(SW), .DW(DW)) u_head (
    .clk      (clk),
    .rst_n    (rst_n),
    .q_busy   (q_wr),
    .in_valid (in_valid),
    .in_ready (in_ready),
    .in_sym   (in_sym),
    .in_last  (in_last),
    .h_v      (lk_v[0]),
    .h_first  (lk_first[0]),
    .h_last   (lk_last[0]),
    .h_sym    (lk_sym[0]),
    .h_d      (lk_d[0])
  );

  for (genvar g = 1; g <= NCELL; g++) begin : g_cell
    logic we;
    assign we = q_wr && (q_idx == IW'(g - 1));
    sed_cell #(.SW(SW), .DW(DW), .ROW(g)) u_cell (
      .clk      (clk),
      .rst_n    (rst_n),
      .q_we     (we),
      .q_sym    (q_sym),
      .up_v     (lk_v[g-1]),
      .up_first (lk_first[g-1]),
      .up_last  (lk_last[g-1]),
      .up_sym   (lk_sym[g-1]),
      .up_d     (lk_d[g-1]),
      .dn_v     (lk_v[g]),
      .dn_first (lk_first[g]),
      .dn_last  (lk_last[g]),
      .dn_sym   (lk_sym[g]),
      .dn_d     (lk_d[g])
    );
  end

  assign res_valid = lk_v[NCELL] & lk_last[NCELL];
  assign res_dist  = lk_d[NCELL];

  // R3
  tail_fwd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lk_v[NCELL] |-> (lk_sym[NCELL] == $past(lk_sym[NCELL-1]) &&
                     lk_first[NCELL] == $past(lk_first[NCELL-1]) &&
                     lk_last[NCELL] == $past(lk_last[NCELL-1])));

endmodule

// File: tb/sed_array_bench.sv
`timescale 1ns/1ps
module sed_array_bench;
  localparam int N = 4, SW = 2, DW = 3, MAXD = 7;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n, q_wr, in_valid, in_last, in_ready, res_valid;
  logic [1:0] q_idx;
  logic [SW-1:0] q_sym, in_sym;
  logic [DW-1:0] res_dist;

  sed_array #(.NCELL(N), .SW(SW), .DW(DW)) u_sed_array (
    .clk(clk), .rst_n(rst_n), .q_wr(q_wr), .q_idx(q_idx), .q_sym(q_sym),
    .in_valid(in_valid), .in_ready(in_ready), .in_sym(in_sym), .in_last(in_last),
    .res_valid(res_valid), .res_dist(res_dist)
  );

  int total = 0, bad = 0;
  int exp_mem [0:4095];
  int wr = 0, rd = 0, tok_n = 0;
  int qry [0:N-1];
  int tgt [0:15];
  bit finished = 0;

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  function automatic int ed(input int tl);
    int d [0:N][0:16];
    for (int i = 0; i <= N; i++) d[i][0] = i;
    for (int j = 0; j <= tl; j++) d[0][j] = j;
    for (int i = 1; i <= N; i++)
      for (int j = 1; j <= tl; j++) begin
        int m;
        m = d[i-1][j-1] + ((qry[i-1] != tgt[j-1]) ? 1 : 0);
        if (d[i-1][j] + 1 < m) m = d[i-1][j] + 1;
        if (d[i][j-1] + 1 < m) m = d[i][j-1] + 1;
        d[i][j] = m;
      end
    return d[N][tl];
  endfunction

  // R4 R7 R8: every result is compared with the next expected value
  always @(negedge clk) begin
    if (rst_n === 1'b1 && res_valid === 1'b1 && !finished) begin
      if (rd < wr) chk(res_dist == DW'(exp_mem[rd]), "R4 R7 R8 distance", int'(res_dist), exp_mem[rd]);
      else chk(1'b0, "R8 unexpected result", int'(res_dist), -1);
      rd++;
    end
  end

  task automatic send_tok(input int s, input bit last);
    bit acc;
    in_valid = 1'b1; in_sym = SW'(s); in_last = last;
    do begin
      #1 acc = in_ready;
      @(posedge clk); @(negedge clk);
    end while (!acc);
    in_valid = 1'b0;
    tok_n++;
    if (tok_n % 5 == 0) @(negedge clk);   // R3 bubble
  endtask

  task automatic send_seq(input int tl);
    int e;
    e = ed(tl);
    exp_mem[wr] = (e > MAXD) ? MAXD : e;
    wr++;
    for (int k = 0; k < tl; k++) send_tok(tgt[k], k == tl - 1);
  endtask

  task automatic load_query(input int a, input int b, input int c, input int d);
    qry[0] = a; qry[1] = b; qry[2] = c; qry[3] = d;
    for (int k = 0; k < N; k++) begin
      q_wr = 1'b1; q_idx = 2'(k); q_sym = SW'(qry[k]);
      @(negedge clk);
    end
    q_wr = 1'b0;
  endtask

  task automatic drain();
    while (rd < wr) @(negedge clk);
    repeat (N + 2) @(negedge clk);
  endtask

  task automatic sweep();
    for (int l = 1; l <= 4; l++)
      for (int n = 0; n < (1 << (2 * l)); n++) begin
        for (int k = 0; k < l; k++) tgt[k] = (n >> (2 * k)) & 3;
        send_seq(l);
      end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; q_wr = 1'b0; q_idx = '0; q_sym = '0;
    in_valid = 1'b0; in_sym = '0; in_last = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    chk(res_valid == 1'b0, "R1 res_valid after reset", int'(res_valid), 0);
    chk(in_ready == 1'b1, "R1 in_ready after reset", int'(in_ready), 1);

    // R2: query loading, then ready held low under a write with a token pending
    load_query(0, 1, 2, 3);
    for (int k = 0; k < 2; k++) begin
      q_wr = 1'b1; q_idx = 2'd2; q_sym = SW'(qry[2]);
      in_valid = 1'b1; in_sym = 2'd3; in_last = 1'b1;
      #1 chk(in_ready == 1'b0, "R2 ready low during query write", int'(in_ready), 0);
      @(negedge clk);
    end
    q_wr = 1'b0; in_valid = 1'b0; in_last = 1'b0;
    repeat (N + 2) @(negedge clk);
    chk(rd == 0, "R2 no token taken during write", rd, 0);

    // R4 R6: exhaustive short targets, back-to-back sequences
    sweep();
    drain();

    // R5: latency of a single-token sequence
    tgt[0] = 0;
    exp_mem[wr] = ed(1); wr++;
    in_valid = 1'b1; in_sym = 2'd0; in_last = 1'b1;
    @(posedge clk); @(negedge clk);
    in_valid = 1'b0; in_last = 1'b0;
    chk(res_valid == 1'b0, "R5 not early", int'(res_valid), 0);
    for (int e = 2; e <= N; e++) begin
      @(negedge clk);
      if (e < N) chk(res_valid == 1'b0, "R5 not early", int'(res_valid), 0);
      else chk(res_valid == 1'b1, "R5 result on edge N", int'(res_valid), 1);
    end
    @(negedge clk);
    chk(res_valid == 1'b0, "R5 single pulse", int'(res_valid), 0);
    drain();

    load_query(3, 3, 0, 0);
    sweep();
    drain();

    // R7: saturation with long targets
    load_query(0, 0, 0, 0);
    sweep();
    for (int k = 0; k < 12; k++) tgt[k] = 3;
    send_seq(12);
    for (int k = 0; k < 11; k++) tgt[k] = (k < 4) ? 0 : 3;
    send_seq(11);
    send_seq(10);
    drain();

    // R8
    chk(rd == wr, "R8 result count", rd, wr);
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule